// File: doc/BRIEF.md
# Counted Streaming Read Ports

This block supplies three read-only streaming data sources for the register file of a small command-processing core. The core names a source with a port select and pulses a read strobe. The block fetches one word and returns it with a one-cycle acknowledge. The memory source reads a 32-bit word at a 64-bit byte address. The register source reads one device register at a 32-bit register index. The queue source pops the next word from an incoming packet queue.

The memory and register sources each keep an address and a word count. The core programs them through a small configuration file, and a read moves its source forward only while that count is nonzero. Once the count is exhausted, further reads return the same location again. Each queue pop lowers a remaining-word counter. If the queue is empty, the block raises a stall flag and holds the read open until a word arrives.

Top module: `stream_read_ports`

## Requirements
- R1: A read with select 0 issues exactly one single-cycle memory request whose 64-bit address is {configuration slot 2, configuration slot 1}, with slot 1 as the low word. The acknowledge carries the returned word.
- R2: On a select-0 read with a nonzero memory count (slot 3), the count drops by 1 and the 64-bit address rises by 4, carrying into the high word.
- R3: On a select-0 or select-1 read whose count is zero, the address and count stay unchanged, so repeated reads return the same location.
- R4: A read with select 1 returns the device register at the index in slot 4, one cycle after the register read pulse. When the count in slot 5 is nonzero, the count drops by 1 and the index rises by 1.
- R5: A read with select 2 pops exactly one queue word and returns it. Each pop lowers the remaining counter in slot 6 by 1.
- R6: A select-2 read on an empty queue raises the stall output with no acknowledge until a word is available. It then pops that word, acknowledges it and drops the stall.
- R7: Configuration slots 0 and 7 always read as zero, and writes to them are ignored.
- R8: After reset, all configuration slots read zero and acknowledge, stall, memory request, register read and queue pop are all low.
- R9: The read strobe is ignored while a read is in progress.
- R10: A read with select 3 acknowledges with zero data and changes no configuration slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read strobe, one cycle |
| rd_sel | input | 2 | Source select: 0 memory, 1 register, 2 queue, 3 none |
| rd_ack | output | 1 | One-cycle read completion |
| rd_data | output | 32 | Read result, valid with rd_ack |
| stall | output | 1 | Queue read waiting on an empty queue |
| cfg_we | input | 1 | Configuration write enable |
| cfg_widx | input | 3 | Configuration write slot |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_ridx | input | 3 | Configuration read slot |
| cfg_rdata | output | 32 | Registered configuration readback |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | 64 | Memory byte address |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rdata | input | 32 | Memory response word |
| greg_rd | output | 1 | Device register read pulse |
| greg_addr | output | 32 | Device register index |
| greg_rdata | input | 32 | Device register value, one cycle after greg_rd |
| q_valid | input | 1 | Queue holds a word |
| q_data | input | 32 | Queue head word |
| q_pop | output | 1 | Queue pop, same cycle as accept |

## Verification
A wrong address or count shows in the very next read of that source as wrong data. It also shows in the configuration readback one cycle after the read is issued. A count that fails to stop at zero makes the fourth of three counted reads return a new location, not the repeated one. A broken queue path shows as a missing or early acknowledge, a stall seen together with an acknowledge, or a remaining count that is off by one pop.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {
    PORT_MEM   = 2'd0,
    PORT_REG   = 2'd1,
    PORT_QUEUE = 2'd2,
    PORT_NONE  = 2'd3
  } port_e;

  localparam int unsigned IDX_W = 3;
  localparam logic [IDX_W-1:0] IX_MADDR_LO = 3'd1;
  localparam logic [IDX_W-1:0] IX_MADDR_HI = 3'd2;
  localparam logic [IDX_W-1:0] IX_MCNT     = 3'd3;
  localparam logic [IDX_W-1:0] IX_RADDR    = 3'd4;
  localparam logic [IDX_W-1:0] IX_RCNT     = 3'd5;
  localparam logic [IDX_W-1:0] IX_REMAIN   = 3'd6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MEM, ST_REG_ISS, ST_REG_WAIT, ST_QWAIT
  } st_e;
endpackage

// File: rtl/srp_ctx.sv
module srp_ctx
  import srp_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned MSTEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DW-1:0]     wdata,
  input  logic [IDX_W-1:0]  ridx,
  input  logic              mem_adv,
  input  logic              reg_adv,
  input  logic              rem_dec,
  output logic [DW-1:0]     rdata,
  output logic [2*DW-1:0]   mem_addr,
  output logic [DW-1:0]     mem_cnt,
  output logic [DW-1:0]     reg_addr,
  output logic [DW-1:0]     reg_cnt,
  output logic [DW-1:0]     remain
);
  localparam int unsigned AW = 2 * DW;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      mem_cnt  <= '0;
      reg_addr <= '0;
      reg_cnt  <= '0;
      remain   <= '0;
      rdata    <= '0;
    end else begin
      if (mem_adv && mem_cnt != '0) begin
        mem_addr <= mem_addr + AW'(MSTEP);
        mem_cnt  <= mem_cnt - 1'b1;
      end
      if (reg_adv && reg_cnt != '0) begin
        reg_addr <= reg_addr + 1'b1;
        reg_cnt  <= reg_cnt - 1'b1;
      end
      if (rem_dec) remain <= remain - 1'b1;
      if (we) begin
        case (widx)
          IX_MADDR_LO: mem_addr[DW-1:0]  <= wdata;
          IX_MADDR_HI: mem_addr[AW-1:DW] <= wdata;
          IX_MCNT:     mem_cnt  <= wdata;
          IX_RADDR:    reg_addr <= wdata;
          IX_RCNT:     reg_cnt  <= wdata;
          IX_REMAIN:   remain   <= wdata;
          default: ;
        endcase
      end
      case (ridx)
        IX_MADDR_LO: rdata <= mem_addr[DW-1:0];
        IX_MADDR_HI: rdata <= mem_addr[AW-1:DW];
        IX_MCNT:     rdata <= mem_cnt;
        IX_RADDR:    rdata <= reg_addr;
        IX_RCNT:     rdata <= reg_cnt;
        IX_REMAIN:   rdata <= remain;
        default:     rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/srp_seq.sv
module srp_seq
  import srp_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_req,
  input  logic [1:0]      rd_sel,
  output logic            rd_ack,
  output logic [DW-1:0]   rd_data,
  output logic            stall,
  input  logic [2*DW-1:0] cur_maddr,
  input  logic [DW-1:0]   cur_raddr,
  output logic            mem_req,
  output logic [2*DW-1:0] mem_addr,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata,
  output logic            greg_rd,
  output logic [DW-1:0]   greg_addr,
  input  logic [DW-1:0]   greg_rdata,
  input  logic            q_valid,
  input  logic [DW-1:0]   q_data,
  output logic            q_pop,
  output logic            mem_adv,
  output logic            reg_adv,
  output logic            rem_dec
);
  st_e   state;
  port_e sel;
  logic  issue;

  assign sel     = port_e'(rd_sel);
  assign issue   = (state == ST_IDLE) && rd_req;
  assign mem_adv = issue && (sel == PORT_MEM);
  assign reg_adv = issue && (sel == PORT_REG);
  assign q_pop   = q_valid && ((issue && sel == PORT_QUEUE) || state == ST_QWAIT);
  assign rem_dec = q_pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rd_ack    <= 1'b0;
      rd_data   <= '0;
      stall     <= 1'b0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      greg_rd   <= 1'b0;
      greg_addr <= '0;
    end else begin
      rd_ack  <= 1'b0;
      mem_req <= 1'b0;
      greg_rd <= 1'b0;
      case (state)
        ST_IDLE: if (rd_req) begin
          case (sel)
            PORT_MEM: begin
              mem_req  <= 1'b1;
              mem_addr <= cur_maddr;
              state    <= ST_MEM;
            end
            PORT_REG: begin
              greg_rd   <= 1'b1;
              greg_addr <= cur_raddr;
              state     <= ST_REG_ISS;
            end
            PORT_QUEUE: begin
              if (q_valid) begin
                rd_ack  <= 1'b1;
                rd_data <= q_data;
              end else begin
                stall <= 1'b1;
                state <= ST_QWAIT;
              end
            end
            default: begin
              rd_ack  <= 1'b1;
              rd_data <= '0;
            end
          endcase
        end
        ST_MEM: if (mem_rvalid) begin
          rd_ack  <= 1'b1;
          rd_data <= mem_rdata;
          state   <= ST_IDLE;
        end
        ST_REG_ISS: state <= ST_REG_WAIT;
        ST_REG_WAIT: begin
          rd_ack  <= 1'b1;
          rd_data <= greg_rdata;
          state   <= ST_IDLE;
        end
        ST_QWAIT: if (q_valid) begin
          rd_ack  <= 1'b1;
          rd_data <= q_data;
          stall   <= 1'b0;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stream_read_ports.sv
module stream_read_ports
  import srp_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned MSTEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_req,
  input  logic [1:0]      rd_sel,
  output logic            rd_ack,
  output logic [DW-1:0]   rd_data,
  output logic            stall,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_widx,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic [2:0]      cfg_ridx,
  output logic [DW-1:0]   cfg_rdata,
  output logic            mem_req,
  output logic [2*DW-1:0] mem_addr,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata,
  output logic            greg_rd,
  output logic [DW-1:0]   greg_addr,
  input  logic [DW-1:0]   greg_rdata,
  input  logic            q_valid,
  input  logic [DW-1:0]   q_data,
  output logic            q_pop
);
  logic [2*DW-1:0] mem_addr_r;
  logic [DW-1:0]   mem_cnt, reg_addr_r, reg_cnt, remain;
  logic            mem_adv, reg_adv, rem_dec;

  srp_ctx #(.DW(DW), .MSTEP(MSTEP)) u_ctx (
    .clk(clk), .rst(rst), .we(cfg_we), .widx(cfg_widx), .wdata(cfg_wdata),
    .ridx(cfg_ridx), .mem_adv(mem_adv), .reg_adv(reg_adv), .rem_dec(rem_dec),
    .rdata(cfg_rdata), .mem_addr(mem_addr_r), .mem_cnt(mem_cnt),
    .reg_addr(reg_addr_r), .reg_cnt(reg_cnt), .remain(remain)
  );

  srp_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_sel(rd_sel),
    .rd_ack(rd_ack), .rd_data(rd_data), .stall(stall),
    .cur_maddr(mem_addr_r), .cur_raddr(reg_addr_r),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .greg_rd(greg_rd), .greg_addr(greg_addr),
    .greg_rdata(greg_rdata), .q_valid(q_valid), .q_data(q_data),
    .q_pop(q_pop), .mem_adv(mem_adv), .reg_adv(reg_adv), .rem_dec(rem_dec)
  );
endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
  parameter int unsigned DW    = 32,
  parameter int unsigned MSTEP = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            rd_ack,
  input logic            stall,
  input logic            cfg_we,
  input logic            mem_req,
  input logic [2*DW-1:0] mem_addr,
  input logic [2*DW-1:0] mem_addr_r,
  input logic [DW-1:0]   mem_cnt,
  input logic            greg_rd,
  input logic [DW-1:0]   reg_addr_r,
  input logic [DW-1:0]   reg_cnt,
  input logic            q_pop
);
  a_r1_single_req: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  a_r1_addr_match: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !$past(cfg_we)) |-> (mem_addr == $past(mem_addr_r)));
  a_r2_mem_step: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_cnt) != '0 && !$past(cfg_we)) |->
      (mem_cnt == $past(mem_cnt) - 1'b1 &&
       mem_addr_r == $past(mem_addr_r) + (2*DW)'(MSTEP)));
  a_r3_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_cnt) == '0 && !$past(cfg_we)) |->
      ($stable(mem_addr_r) && mem_cnt == '0));
  a_r4_reg_step: assert property (@(posedge clk) disable iff (rst)
    (greg_rd && $past(reg_cnt) != '0 && !$past(cfg_we)) |->
      (reg_addr_r == $past(reg_addr_r) + 1'b1));
  a_r5_pop_then_ack: assert property (@(posedge clk) disable iff (rst)
    q_pop |=> rd_ack);
  a_r6_stall_excl_ack: assert property (@(posedge clk) disable iff (rst)
    !(stall && rd_ack));
endmodule

bind stream_read_ports srp_checker #(.DW(DW), .MSTEP(MSTEP)) u_chk (
  .clk(clk), .rst(rst), .rd_ack(rd_ack), .stall(stall), .cfg_we(cfg_we),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_addr_r(mem_addr_r),
  .mem_cnt(mem_cnt), .greg_rd(greg_rd), .reg_addr_r(reg_addr_r),
  .reg_cnt(reg_cnt), .q_pop(q_pop)
);

// File: tb/tb_stream_read_ports.sv
`timescale 1ns/1ps
module tb_stream_read_ports;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_req = 1'b0;
  logic [1:0]  rd_sel = 2'd0;
  logic        rd_ack, stall;
  logic [31:0] rd_data;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_widx = 3'd0, cfg_ridx = 3'd0;
  logic [31:0] cfg_wdata = 32'd0, cfg_rdata;
  logic        mem_req, greg_rd, q_pop, q_valid;
  logic [63:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = 32'd0, greg_rdata = 32'd0, greg_addr, q_data;

  always #10 clk = ~clk;

  stream_read_ports dut (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_sel(rd_sel), .rd_ack(rd_ack),
    .rd_data(rd_data), .stall(stall), .cfg_we(cfg_we), .cfg_widx(cfg_widx),
    .cfg_wdata(cfg_wdata), .cfg_ridx(cfg_ridx), .cfg_rdata(cfg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .greg_rd(greg_rd), .greg_addr(greg_addr),
    .greg_rdata(greg_rdata), .q_valid(q_valid), .q_data(q_data), .q_pop(q_pop)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  bit busy_tb = 0;
  int greg_pulses = 0;

  function automatic logic [31:0] memval(input logic [63:0] a);
    return (a[31:0] * 32'd3) ^ a[63:32] ^ 32'h5A000000;
  endfunction
  function automatic logic [31:0] gval(input logic [31:0] a);
    return a * 32'd7 + 32'd1;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder with programmable latency
  int mlat = 0, mcnt = 0;
  bit mpend = 0;
  logic [63:0] maddr_l;
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst) mpend <= 0;
    else if (mem_req) begin mpend <= 1; mcnt <= mlat; maddr_l <= mem_addr; end
    else if (mpend) begin
      if (mcnt == 0) begin mem_rvalid <= 1'b1; mem_rdata <= memval(maddr_l); mpend <= 0; end
      else mcnt <= mcnt - 1;
    end
  end

  // device registers, one-cycle read
  always @(posedge clk) if (greg_rd) begin
    greg_rdata <= gval(greg_addr);
    greg_pulses <= greg_pulses + 1;
  end

  // packet queue
  logic [31:0] qbuf [16];
  int qh = 0, qt = 0;
  assign q_valid = (qh != qt);
  assign q_data  = qbuf[qh % 16];
  always @(posedge clk) if (q_pop) qh <= qh + 1;
  task automatic push(input logic [31:0] v);
    qbuf[qt % 16] = v;
    qt = qt + 1;
  endtask

  // per-clock model of handshake outputs
  always @(negedge clk) if (!rst && !done) begin
    if (rd_ack && !busy_tb) begin errors++; $display("FAIL R9: actual ack expected none"); end
    if (stall && !busy_tb)  begin errors++; $display("FAIL R6: actual stall expected none"); end
  end

  task automatic cfg_write(input logic [2:0] i, input logic [31:0] v);
    @(negedge clk); cfg_we = 1; cfg_widx = i; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic cfg_read(input logic [2:0] i, output logic [31:0] v);
    @(negedge clk); cfg_ridx = i;
    @(negedge clk); v = cfg_rdata;
  endtask
  task automatic do_read(input logic [1:0] s, output logic [31:0] v);
    int n;
    @(negedge clk); rd_req = 1; rd_sel = s; busy_tb = 1;
    @(negedge clk); rd_req = 0;
    n = 0;
    while (!rd_ack && n < 200) begin @(negedge clk); n++; end
    v = rd_data;
    @(negedge clk); busy_tb = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] ea;
    logic [31:0] ec;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R8 reset state
    chk("R8 ack", rd_ack, 0); chk("R8 stall", stall, 0);
    chk("R8 memreq", mem_req, 0); chk("R8 gregrd", greg_rd, 0); chk("R8 pop", q_pop, 0);
    for (int i = 0; i < 8; i++) begin cfg_read(3'(i), v); chk("R8 slot", v, 0); end
    // R7 reserved slots
    cfg_write(3'd0, 32'hDEADBEEF); cfg_read(3'd0, v); chk("R7 slot0", v, 0);
    cfg_write(3'd7, 32'h12345678); cfg_read(3'd7, v); chk("R7 slot7", v, 0);
    // R1 R2 R3 memory source with carry into high word
    cfg_write(3'd1, 32'hFFFFFFF8); cfg_write(3'd2, 32'h1); cfg_write(3'd3, 32'd3);
    ea = 64'h1_FFFFFFF8; ec = 3;
    for (int k = 0; k < 5; k++) begin
      mlat = k % 3;
      do_read(2'd0, v);
      chk(k < 3 ? "R1 memdata" : "R3 memrepeat", v, memval(ea));
      if (ec != 0) begin ec--; ea += 4; end
    end
    cfg_read(3'd1, v); chk("R2 addr lo", v, ea[31:0]);
    cfg_read(3'd2, v); chk("R2 addr hi", v, 32'h2);
    cfg_read(3'd3, v); chk("R3 count zero", v, 0);
    // R4 R3 register source
    cfg_write(3'd4, 32'd10); cfg_write(3'd5, 32'd2);
    do_read(2'd1, v); chk("R4 reg0", v, gval(10));
    do_read(2'd1, v); chk("R4 reg1", v, gval(11));
    do_read(2'd1, v); chk("R3 reg at end", v, gval(12));
    do_read(2'd1, v); chk("R3 reg repeat", v, gval(12));
    cfg_read(3'd4, v); chk("R3 reg addr held", v, 12);
    // R5 queue source
    cfg_write(3'd6, 32'd5);
    push(32'h111); push(32'h222);
    do_read(2'd2, v); chk("R5 pop0", v, 32'h111);
    do_read(2'd2, v); chk("R5 pop1", v, 32'h222);
    cfg_read(3'd6, v); chk("R5 remain", v, 3);
    // R6 empty queue
    @(negedge clk); rd_req = 1; rd_sel = 2'd2; busy_tb = 1;
    @(negedge clk); rd_req = 0;
    repeat (4) @(negedge clk);
    chk("R6 stall high", stall, 1); chk("R6 no ack", rd_ack, 0);
    push(32'h333);
    @(negedge clk); chk("R6 ack", rd_ack, 1); chk("R6 data", rd_data, 32'h333);
    chk("R6 stall drop", stall, 0);
    @(negedge clk); busy_tb = 0;
    cfg_read(3'd6, v); chk("R6 remain", v, 2);
    // R9 strobe ignored during a read
    cfg_write(3'd5, 32'd1);
    greg_pulses = 0;
    mlat = 6;
    @(negedge clk); rd_req = 1; rd_sel = 2'd0; busy_tb = 1;
    @(negedge clk); rd_req = 0;
    @(negedge clk); rd_req = 1; rd_sel = 2'd1;
    @(negedge clk); rd_req = 0;
    while (!rd_ack) @(negedge clk);
    chk("R9 mem data", rd_data, memval(ea));
    @(negedge clk); busy_tb = 0;
    repeat (3) @(negedge clk);
    chk("R9 no greg read", greg_pulses, 0);
    cfg_read(3'd5, v); chk("R9 reg count kept", v, 1);
    // R10 no-source select
    cfg_write(3'd3, 32'd4);
    do_read(2'd3, v); chk("R10 zero data", v, 0);
    cfg_read(3'd3, v); chk("R10 mem count kept", v, 4);
    cfg_read(3'd4, v); chk("R10 reg addr kept", v, 12);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule